// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns a vector operation of any length `n` into a series of chunks, none longer than the maximum vector length `MVL`. For each chunk it presents the vector length value and the index of the chunk's first element. It then steps through the chunk, offering one element index per clock to a downstream functional unit that accepts elements with a ready signal.

The chunk that is not a full `MVL` (the `n mod MVL` remainder) is issued first, starting at element 0. Every later chunk is a full `MVL`, and each chunk's base is the previous base plus the previous chunk's length. When `n` is an exact multiple of `MVL`, no empty chunk is issued and the first chunk is already full. A one-cycle done pulse follows the last accepted element. An operation of length zero completes at once without issuing anything.

Top module: `vl_seq`

## Requirements
- R1: After reset `doneO`, `elemValidO`, `vlO`, `baseO` and `elemIdxO` are all zero.
- R2: When `n mod MVL` is not zero, the first chunk has `vlO = n mod MVL` and `baseO = 0`.
- R3: Every chunk after the first has `vlO = MVL`, and its `baseO` equals the previous chunk's `baseO` plus the previous chunk's `vlO`.
- R4: When `n` is a nonzero multiple of `MVL`, the first chunk has `vlO = MVL` and `baseO = 0`, and no zero-length chunk appears.
- R5: `elemValidO` rises in the cycle after the start is taken. It stays high with no gap across chunk boundaries until `n` elements are accepted. The accepted `elemIdxO` values are 0, 1, ..., n-1 in order.
- R6: While `elemValidO` is high and `readyI` is low, `elemIdxO`, `vlO` and `baseO` hold their values, so no index is lost or repeated.
- R7: `doneO` is high for exactly one cycle, the cycle after the last element is accepted, and `elemValidO` is low in that cycle.
- R8: A start with `nI = 0` raises `doneO` in the next cycle, and no element is issued.
- R9: `startI` has no effect while elements are being issued. The running sequence continues unchanged.
- R10: A start asserted in the cycle `doneO` is high is taken, and the new operation begins issuing in the next cycle.
- R11: While `elemValidO` is high, `vlO` is between 1 and `MVL`, and `baseO <= elemIdxO < baseO + vlO`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startI | input | 1 | Start strobe, taken only when idle |
| nI | input | N_W | Total element count, captured with the start |
| readyI | input | 1 | Downstream accepts the offered element |
| vlO | output | VL_W | Length of the current chunk |
| baseO | output | N_W | Element index at which the current chunk starts |
| elemValidO | output | 1 | An element index is offered |
| elemIdxO | output | N_W | Offered element index |
| doneO | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first is the completion pulse of one operation and the start of the next. The bench chains operations by raising the start in the very cycle it sees `doneO`, then checks that the new operation's element 0 appears one cycle later with no stale done. The second is the acceptance of a chunk's last element and the switch to the next chunk. The bench provokes it with ready patterns that stall around boundaries, and judges it by the uninterrupted index run and the new `vlO`/`baseO` pair on the following element.

// File: rtl/vl_seq_pkg.sv
package vl_seq_pkg;

  // Strobes from the control FSM to the datapath registers
  typedef struct packed {
    logic load;       // capture n, set up first chunk
    logic step;       // advance element offset inside chunk
    logic nextChunk;  // move base, reload full length
    logic finish;     // operation complete
  } seqStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_e;

endpackage

// File: rtl/vl_seq_dp.sv
module vl_seq_dp
  import vl_seq_pkg::*;
#(
  parameter int MVL = 64,
  parameter int N_W = 16,
  localparam int VL_W = $clog2(MVL + 1),
  localparam int OFF_W = (MVL > 1) ? $clog2(MVL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_W-1:0]   nI,
  input  seqStrobe_t       strb,
  output logic             nZero,
  output logic             chunkEnd,
  output logic             lastChunk,
  output logic [VL_W-1:0]  vlO,
  output logic [N_W-1:0]   baseO,
  output logic [N_W-1:0]   elemIdxO
);

  logic [N_W-1:0]   nQ;
  logic [N_W-1:0]   baseQ;
  logic [VL_W-1:0]  vlQ;
  logic [OFF_W-1:0] offQ;

  logic [N_W-1:0]   remFull;
  logic [VL_W-1:0]  firstLen;
  logic [N_W:0]     chunkTop;

  // Remainder chunk goes first; a zero remainder means a full first chunk
  always_comb begin
    remFull  = nI % N_W'(MVL);
    firstLen = (remFull == '0) ? VL_W'(MVL) : VL_W'(remFull);
    nZero    = (nI == '0);
  end

  always_comb begin
    chunkEnd  = (VL_W'(offQ) == (vlQ - VL_W'(1)));
    chunkTop  = (N_W+1)'(baseQ) + (N_W+1)'(vlQ);
    lastChunk = (chunkTop == (N_W+1)'(nQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nQ    <= '0;
      baseQ <= '0;
      vlQ   <= '0;
      offQ  <= '0;
    end else if (strb.load) begin
      nQ    <= nI;
      baseQ <= '0;
      vlQ   <= nZero ? '0 : firstLen;
      offQ  <= '0;
    end else if (strb.nextChunk) begin
      baseQ <= N_W'(chunkTop);
      vlQ   <= VL_W'(MVL);
      offQ  <= '0;
    end else if (strb.step) begin
      offQ  <= offQ + OFF_W'(1);
    end
  end

  assign vlO      = vlQ;
  assign baseO    = baseQ;
  assign elemIdxO = baseQ + N_W'(offQ);

endmodule

// File: rtl/vl_seq_ctrl.sv
module vl_seq_ctrl
  import vl_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic       readyI,
  input  logic       nZero,
  input  logic       chunkEnd,
  input  logic       lastChunk,
  output seqStrobe_t strb,
  output logic       elemValid,
  output logic       doneO
);

  seqState_e stateQ, stateD;
  logic      accept;
  logic      doneQ;

  assign elemValid = (stateQ == ST_RUN);
  assign accept    = elemValid && readyI;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (startI) begin
          strb.load = 1'b1;
          if (nZero) strb.finish = 1'b1;
          else       stateD      = ST_RUN;
        end
      end
      ST_RUN: begin
        if (accept) begin
          if (!chunkEnd) begin
            strb.step = 1'b1;
          end else if (lastChunk) begin
            strb.finish = 1'b1;
            stateD      = ST_IDLE;
          end else begin
            strb.nextChunk = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strb.finish;
    end
  end

  assign doneO = doneQ;

endmodule

// File: rtl/vl_seq.sv
module vl_seq
  import vl_seq_pkg::*;
#(
  parameter int MVL = 64,
  parameter int N_W = 16,
  localparam int VL_W = $clog2(MVL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startI,
  input  logic [N_W-1:0]  nI,
  input  logic            readyI,
  output logic [VL_W-1:0] vlO,
  output logic [N_W-1:0]  baseO,
  output logic            elemValidO,
  output logic [N_W-1:0]  elemIdxO,
  output logic            doneO
);

  seqStrobe_t strb;
  logic nZero, chunkEnd, lastChunk;

  vl_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startI    (startI),
    .readyI    (readyI),
    .nZero     (nZero),
    .chunkEnd  (chunkEnd),
    .lastChunk (lastChunk),
    .strb      (strb),
    .elemValid (elemValidO),
    .doneO     (doneO)
  );

  vl_seq_dp #(.MVL(MVL), .N_W(N_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .nI        (nI),
    .strb      (strb),
    .nZero     (nZero),
    .chunkEnd  (chunkEnd),
    .lastChunk (lastChunk),
    .vlO       (vlO),
    .baseO     (baseO),
    .elemIdxO  (elemIdxO)
  );

endmodule

// File: rtl/vl_seq_chk.sv
module vl_seq_chk #(
  parameter int MVL = 64,
  parameter int N_W = 16,
  localparam int VL_W = $clog2(MVL + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            startI,
  input logic            readyI,
  input logic [VL_W-1:0] vlO,
  input logic [N_W-1:0]  baseO,
  input logic            elemValidO,
  input logic [N_W-1:0]  elemIdxO,
  input logic            doneO
);

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemValidO && readyI) |=> (!elemValidO || elemIdxO == $past(elemIdxO) + N_W'(1)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemValidO && !readyI) |=> (elemValidO && $stable(elemIdxO) && $stable(vlO) && $stable(baseO)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && !startI) |=> !doneO);

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneO && elemValidO));

  // R11
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    elemValidO |-> (vlO != '0 && vlO <= VL_W'(MVL) && elemIdxO >= baseO
                    && (elemIdxO - baseO) < N_W'(vlO)));

endmodule

bind vl_seq vl_seq_chk #(.MVL(MVL), .N_W(N_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startI     (startI),
  .readyI     (readyI),
  .vlO        (vlO),
  .baseO      (baseO),
  .elemValidO (elemValidO),
  .elemIdxO   (elemIdxO),
  .doneO      (doneO)
);

// File: tb/vl_seq_test.sv
module vl_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int M   = 8;
  localparam int NW  = 8;
  localparam int VLW = $clog2(M + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 1'b0;
  logic [NW-1:0] nI = '0;
  logic readyI = 1'b0;
  logic [VLW-1:0] vlO;
  logic [NW-1:0] baseO;
  logic elemValidO;
  logic [NW-1:0] elemIdxO;
  logic doneO;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vl_seq #(.MVL(M), .N_W(NW)) uut (
    .clk(clk), .rstN(rstN), .startI(startI), .nI(nI), .readyI(readyI),
    .vlO(vlO), .baseO(baseO), .elemValidO(elemValidO),
    .elemIdxO(elemIdxO), .doneO(doneO)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finishRun();
    end
  end

  // Caller raises startI/nI at a negedge, then calls this task.
  task automatic runOp(int n, int mode, bit chainNext, int nextN, bit poke);
    int k = 0;
    int guard = 0;
    int first = (n % M == 0) ? M : (n % M);
    if (n == 0) begin
      @(negedge clk);
      startI = 0;
      // R8: done the cycle after start, nothing issued
      check(doneO == 1'b1, "R8 done", int'(doneO), 1);
      check(elemValidO == 1'b0, "R8 no element", int'(elemValidO), 0);
    end else begin
      while (k < n && guard < 2000) begin
        int expLen;
        int expBase;
        bit r;
        @(negedge clk);
        guard++;
        startI = 0;
        if (poke && k == 3) begin
          startI = 1; nI = 8'd3;  // R9: must be ignored
        end
        check(doneO == 1'b0, "R7 no early done", int'(doneO), 0);
        // R5: valid continuous through chunk boundaries
        check(elemValidO == 1'b1, "R5 valid", int'(elemValidO), 1);
        expLen  = (k < first) ? first : M;
        expBase = (k < first) ? 0 : first + ((k - first) / M) * M;
        if (elemValidO) begin
          if (k < first && n % M != 0)
            check(int'(vlO) == expLen, "R2 first vl", int'(vlO), expLen);
          else if (k < first)
            check(int'(vlO) == expLen, "R4 full first vl", int'(vlO), expLen);
          else
            check(int'(vlO) == expLen, "R3 later vl", int'(vlO), expLen);
          check(int'(baseO) == expBase, "R3 base", int'(baseO), expBase);
          // R5 R6: index equals count of accepted elements
          check(int'(elemIdxO) == k, "R5 R6 idx", int'(elemIdxO), k);
        end
        r = (mode == 0) ? 1'b1 : (((guard * 7 + n) % 5) != 0) && (((guard + k) % 11) != 3);
        readyI = r;
        if (elemValidO && r) k++;
      end
      @(negedge clk);
      readyI = 0;
      startI = 0;
      check(doneO == 1'b1, "R7 done", int'(doneO), 1);
      check(elemValidO == 1'b0, "R7 valid low at done", int'(elemValidO), 0);
    end
    if (chainNext) begin
      startI = 1; nI = NW'(nextN);  // R10: start in the done cycle
    end else begin
      @(negedge clk);
      check(doneO == 1'b0, "R7 single pulse", int'(doneO), 0);
      check(elemValidO == 1'b0, "R9 idle", int'(elemValidO), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(doneO == 0 && elemValidO == 0, "R1 ctrl", int'({doneO, elemValidO}), 0);
    check(vlO == 0 && baseO == 0 && elemIdxO == 0, "R1 data", int'(vlO) + int'(baseO), 0);
    rstN = 1;
    @(negedge clk);
    for (int mode = 0; mode < 2; mode++) begin
      for (int n = 0; n <= 3 * M + 3; n++) begin
        startI = 1; nI = NW'(n);
        runOp(n, mode, 0, 0, 0);
      end
    end
    // R9: start pulses mid-run
    startI = 1; nI = NW'(20);
    runOp(20, 1, 0, 0, 1);
    startI = 1; nI = NW'(M);
    runOp(M, 0, 0, 0, 1);
    // R10: back-to-back chains
    startI = 1; nI = NW'(11);
    runOp(11, 1, 1, 5, 0);
    runOp(5, 0, 1, 2 * M, 0);
    runOp(2 * M, 1, 1, 1, 0);
    runOp(1, 0, 0, 0, 0);
    finishRun();
  end

endmodule